// File: doc/BRIEF.md
# DRAM Row Refresh Controller

This controller sits between a host and a bit-wide DRAM array of 512 rows by 512 columns. It drives the array over one shared address bus of half the host address width. A host request carries an 18-bit address and a write flag. The controller first presents the row half of the address with a row strobe, and on the next clock the column half with a column strobe. Read data comes back to the host one clock after the column phase.

A programmable interval timer raises refresh requests. When the controller is idle and a request is pending, it runs a refresh burst. The burst walks every row from 0 upward, spending one clock reading the row into the array's row latch and one clock writing it back. While a burst runs, the controller reports a stall. Host requests that arrive during the burst are held in a small in-order queue and served once the burst is over.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: While reset is held, `mem_ras`, `mem_cas`, `host_stall`, `host_full` and `rd_valid` are all 0.
- R2: A host request accepted at clock edge E, with the controller idle, produces a row phase visible after edge E+1. The row phase is `mem_ras`=1, `mem_cas`=0, and `mem_addr` equal to host address bits [HALF_W-1:0] (bits 0 to 8 by default).
- R3: The clock after the row phase is the column phase: `mem_cas`=1, `mem_ras`=0, `mem_addr` equal to host address bits [2*HALF_W-1:HALF_W], `mem_we` equal to the request's write flag, and, for writes, `mem_wdata` equal to the request data.
- R4: For a read, `rd_valid` is 1 for exactly the clock after the column phase, and `rd_data` holds the bit addressed in the array. `rd_valid` is never 1 at any other time.
- R5: `mem_ras` and `mem_cas` are never 1 together, and each host strobe lasts one clock.
- R6: With `rfsh_interval`=N>0, a refresh request is raised every N clocks. A value of 0 disables refresh. A burst starts only from idle, never while a host access is in its row or column phase. With no host traffic and N > 2*rows+1, bursts begin exactly N clocks apart.
- R7: A burst visits each row in ascending order. Each row takes two clocks: a read clock (`mem_ras`=1, `mem_we`=0) and then a write-back clock (`mem_ras`=1, `mem_we`=1) on the same row. `host_stall` is high for exactly 2*rows clocks per burst.
- R8: The refresh row counter wraps from the last row to 0, and every burst begins at row 0.
- R9: Requests that arrive while `host_stall` is high are queued. They are served in arrival order after the burst. `host_full` is 1 when the queue holds QDEPTH entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rfsh_interval | input | CNT_W | Refresh period in clocks; 0 disables refresh |
| host_valid | input | 1 | Host request present this clock |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2*HALF_W | Low half is the row, high half is the column |
| host_wdata | input | 1 | Write data bit |
| host_full | output | 1 | Request queue full; host must not present a request |
| host_stall | output | 1 | Refresh burst in progress; host access is held off |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 1 | Read data bit |
| mem_addr | output | HALF_W | Multiplexed row/column address to the array |
| mem_ras | output | 1 | Row strobe |
| mem_cas | output | 1 | Column strobe |
| mem_we | output | 1 | Array write enable (column write, or refresh write-back) |
| mem_wdata | output | 1 | Array write data |
| mem_rdata | input | 1 | Array read data, combinational from the latched row and `mem_addr` |

## Verification
The timing of a host access is fixed when the queue is empty and refresh is off. The row phase is due two edges after the request is driven, the column phase three edges after, and read data four edges after. The bench samples at the falling edge after each of those edges. Refresh results are checked by a falling-edge monitor that follows the strobes continuously: the row order, whether a burst starts at row 0 from an idle bus, the exact length of each burst, and the exact spacing between burst starts. Queued traffic has no fixed latency behind a burst, so those checks wait for `rd_valid` with a bound and compare the data and the order of the row phases.

// File: rtl/dref_pkg.sv
package dref_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ROW   = 3'd1,
        ST_COL   = 3'd2,
        ST_RF_RD = 3'd3,
        ST_RF_WB = 3'd4
    } dref_state_e;

    typedef struct packed {
        logic ras;
        logic cas;
        logic we;
    } dref_strobe_t;

endpackage

// File: rtl/dref_interval.sv
module dref_interval #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] interval,
    output logic             tick
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_q, tmr_d;

    always_comb begin
        tmr_d = tmr_q;
        tick  = 1'b0;
        if (interval == '0) begin
            tmr_d.cnt = '0;
        end else if (tmr_q.cnt >= interval - 1'b1) begin
            tick      = 1'b1;
            tmr_d.cnt = '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end
endmodule

// File: rtl/dref_reqq.sv
module dref_reqq #(
    parameter int AW    = 18,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          push_we,
    input  logic [AW-1:0] push_addr,
    input  logic          push_wdata,
    input  logic          pop,
    output logic          empty,
    output logic          full,
    output logic          head_we,
    output logic [AW-1:0] head_addr,
    output logic          head_wdata
);
    localparam int EW = AW + 2;
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][EW-1:0] slot;
        logic [PW-1:0]            wp;
        logic [PW-1:0]            rp;
        logic [PW:0]              cnt;
    } q_t;

    q_t q_q, q_d;
    logic push_ok;

    assign empty = (q_q.cnt == '0);
    assign full  = (q_q.cnt == (PW+1)'(DEPTH));
    assign push_ok = push && !full;
    assign {head_we, head_addr, head_wdata} = q_q.slot[q_q.rp];

    always_comb begin
        q_d = q_q;
        if (push_ok) begin
            q_d.slot[q_q.wp] = {push_we, push_addr, push_wdata};
            q_d.wp = (q_q.wp == PW'(DEPTH - 1)) ? '0 : q_q.wp + 1'b1;
        end
        if (pop && !empty) begin
            q_d.rp = (q_q.rp == PW'(DEPTH - 1)) ? '0 : q_q.rp + 1'b1;
        end
        if (push_ok && !(pop && !empty))      q_d.cnt = q_q.cnt + 1'b1;
        else if (!push_ok && (pop && !empty)) q_d.cnt = q_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end
endmodule

// File: rtl/dref_seq.sv
module dref_seq
    import dref_pkg::*;
#(
    parameter int HALF_W = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  q_empty,
    input  logic                  head_we,
    input  logic [2*HALF_W-1:0]   head_addr,
    input  logic                  head_wdata,
    output logic                  pop,
    output logic [HALF_W-1:0]     mem_addr,
    output dref_strobe_t          strobe,
    output logic                  mem_wdata,
    input  logic                  mem_rdata,
    output logic                  rd_valid,
    output logic                  rd_data,
    output logic                  rfsh_act
);
    localparam int ADDR_W = 2 * HALF_W;
    localparam logic [HALF_W-1:0] ROW_LAST = '1;

    typedef struct packed {
        dref_state_e        st;
        logic [HALF_W-1:0]  row;
        logic               pend;
        logic               cur_we;
        logic [ADDR_W-1:0]  cur_addr;
        logic               cur_wdata;
        logic               rdv;
        logic               rdd;
    } seq_t;

    seq_t s_q, s_d;

    always_comb begin
        s_d      = s_q;
        pop      = 1'b0;
        s_d.pend = s_q.pend | tick;
        s_d.rdv  = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (s_q.pend) begin
                    s_d.st   = ST_RF_RD;
                    s_d.pend = tick;
                end else if (!q_empty) begin
                    pop           = 1'b1;
                    s_d.cur_we    = head_we;
                    s_d.cur_addr  = head_addr;
                    s_d.cur_wdata = head_wdata;
                    s_d.st        = ST_ROW;
                end
            end
            ST_ROW: s_d.st = ST_COL;
            ST_COL: begin
                s_d.st = ST_IDLE;
                if (!s_q.cur_we) begin
                    s_d.rdv = 1'b1;
                    s_d.rdd = mem_rdata;
                end
            end
            ST_RF_RD: s_d.st = ST_RF_WB;
            ST_RF_WB: begin
                s_d.row = s_q.row + 1'b1;
                s_d.st  = (s_q.row == ROW_LAST) ? ST_IDLE : ST_RF_RD;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_comb begin
        strobe    = '0;
        mem_addr  = '0;
        mem_wdata = 1'b0;
        unique case (s_q.st)
            ST_ROW: begin
                strobe.ras = 1'b1;
                mem_addr   = s_q.cur_addr[HALF_W-1:0];
            end
            ST_COL: begin
                strobe.cas = 1'b1;
                strobe.we  = s_q.cur_we;
                mem_addr   = s_q.cur_addr[ADDR_W-1:HALF_W];
                mem_wdata  = s_q.cur_we & s_q.cur_wdata;
            end
            ST_RF_RD: begin
                strobe.ras = 1'b1;
                mem_addr   = s_q.row;
            end
            ST_RF_WB: begin
                strobe.ras = 1'b1;
                strobe.we  = 1'b1;
                mem_addr   = s_q.row;
            end
            default: ;
        endcase
    end

    assign rd_valid = s_q.rdv;
    assign rd_data  = s_q.rdd;
    assign rfsh_act = (s_q.st == ST_RF_RD) || (s_q.st == ST_RF_WB);

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
    import dref_pkg::*;
#(
    parameter int HALF_W = 9,
    parameter int QDEPTH = 4,
    parameter int CNT_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CNT_W-1:0]    rfsh_interval,
    input  logic                host_valid,
    input  logic                host_we,
    input  logic [2*HALF_W-1:0] host_addr,
    input  logic                host_wdata,
    output logic                host_full,
    output logic                host_stall,
    output logic                rd_valid,
    output logic                rd_data,
    output logic [HALF_W-1:0]   mem_addr,
    output logic                mem_ras,
    output logic                mem_cas,
    output logic                mem_we,
    output logic                mem_wdata,
    input  logic                mem_rdata
);
    localparam int ADDR_W = 2 * HALF_W;

    logic              tick;
    logic              q_empty;
    logic              pop;
    logic              head_we;
    logic [ADDR_W-1:0] head_addr;
    logic              head_wdata;
    logic              rfsh_act;
    dref_strobe_t      strobe;

    dref_interval #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .interval (rfsh_interval),
        .tick     (tick)
    );

    dref_reqq #(.AW(ADDR_W), .DEPTH(QDEPTH)) u_q (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (host_valid),
        .push_we    (host_we),
        .push_addr  (host_addr),
        .push_wdata (host_wdata),
        .pop        (pop),
        .empty      (q_empty),
        .full       (host_full),
        .head_we    (head_we),
        .head_addr  (head_addr),
        .head_wdata (head_wdata)
    );

    dref_seq #(.HALF_W(HALF_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .q_empty    (q_empty),
        .head_we    (head_we),
        .head_addr  (head_addr),
        .head_wdata (head_wdata),
        .pop        (pop),
        .mem_addr   (mem_addr),
        .strobe     (strobe),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .rfsh_act   (rfsh_act)
    );

    assign mem_ras    = strobe.ras;
    assign mem_cas    = strobe.cas;
    assign mem_we     = strobe.we;
    assign host_stall = rfsh_act;
endmodule

// File: rtl/dref_checker.sv
module dref_checker #(
    parameter int HALF_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic [HALF_W-1:0] mem_addr,
    input logic              mem_ras,
    input logic              mem_cas,
    input logic              mem_we,
    input logic              rd_valid,
    input logic              rfsh_act
);
    assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_ras, mem_cas}));

    assert_cas_one_clock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cas |=> !mem_cas);

    assert_row_then_col_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ras && !mem_we && !rfsh_act) |=> (mem_cas && !mem_ras));

    assert_rd_after_col_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(mem_cas && !mem_we));

    assert_wb_same_row_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ras && mem_we) |-> ($past(mem_ras && !mem_we) && mem_addr == $past(mem_addr)));

    assert_rows_ascend_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rfsh_act && mem_ras && !mem_we && $past(rfsh_act))
            |-> mem_addr == HALF_W'($past(mem_addr) + 1'b1));

    assert_burst_from_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rfsh_act) |-> (mem_addr == '0 && $past(!mem_ras && !mem_cas)));

    assert_no_host_in_burst_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_act |-> !mem_cas);
endmodule

bind dram_refresh_ctrl dref_checker #(.HALF_W(HALF_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_addr (mem_addr),
    .mem_ras  (mem_ras),
    .mem_cas  (mem_cas),
    .mem_we   (mem_we),
    .rd_valid (rd_valid),
    .rfsh_act (rfsh_act)
);

// File: tb/sim_dram_refresh_ctrl.sv
`timescale 1ns/1ps
module sim_dram_refresh_ctrl;
    localparam int HW   = 4;
    localparam int ROWS = 1 << HW;
    localparam int CW   = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] rfsh_interval = '0;
    logic          host_valid = 1'b0;
    logic          host_we = 1'b0;
    logic [2*HW-1:0] host_addr = '0;
    logic          host_wdata = 1'b0;
    logic          host_full, host_stall, rd_valid, rd_data;
    logic [HW-1:0] mem_addr;
    logic          mem_ras, mem_cas, mem_we, mem_wdata, mem_rdata;

    always #2 clk = ~clk;

    dram_refresh_ctrl #(.HALF_W(HW), .QDEPTH(4), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .rfsh_interval(rfsh_interval),
        .host_valid(host_valid), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_full(host_full), .host_stall(host_stall),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
        .mem_ras(mem_ras), .mem_cas(mem_cas), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // behavioural array: row latch filled by a row phase, written back by refresh
    logic [ROWS-1:0] arr [ROWS];
    logic [HW-1:0]   row_latch = '0;
    logic [ROWS-1:0] rowbuf = '0;
    initial for (int i = 0; i < ROWS; i++) arr[i] = '0;
    assign mem_rdata = arr[row_latch][mem_addr];
    always @(posedge clk) begin
        if (mem_ras && !mem_we) begin
            row_latch <= mem_addr;
            rowbuf    <= arr[mem_addr];
        end
        if (mem_ras && mem_we) arr[mem_addr] <= rowbuf;
        if (mem_cas && mem_we) arr[row_latch][mem_addr] <= mem_wdata;
    end

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic pat(input logic [2*HW-1:0] a);
        return ^(a & 8'hB5);
    endfunction

    // refresh monitor
    bit            mon_en = 0;
    bit            spacing_mode = 0;
    int            exp_int = 0;
    logic [HW-1:0] exp_row = '0;
    bit            prev_stall = 0, prev_ras = 0, prev_cas = 0;
    int            run_len = 0;
    int            last_rise = -1;
    int            rises = 0;
    logic [HW-1:0] hist [8];
    int            hn = 0;

    always @(negedge clk) begin
        cyc++;
        if (mon_en) begin
            if (mem_ras && mem_we) begin
                chk(mem_addr == exp_row, "R7 write-back row", mem_addr, exp_row);
                exp_row <= exp_row + 1'b1;
            end
            if (mem_ras && !mem_we && host_stall)
                chk(mem_addr == exp_row, "R7 refresh read row", mem_addr, exp_row);
            if (mem_ras && !mem_we && !host_stall && hn < 8) begin
                hist[hn] = mem_addr;
                hn++;
            end
            if (host_stall && !prev_stall) begin
                chk(mem_addr == '0 && exp_row == '0, "R8 burst starts at row 0", mem_addr, 0);
                chk(!prev_ras && !prev_cas, "R6 burst only from idle", {prev_ras, prev_cas}, 0);
                if (spacing_mode && last_rise >= 0)
                    chk(cyc - last_rise == exp_int, "R6 burst spacing", cyc - last_rise, exp_int);
                last_rise = cyc;
                rises++;
            end
            if (!host_stall && prev_stall)
                chk(run_len == 2 * ROWS, "R7 burst length", run_len, 2 * ROWS);
            run_len = host_stall ? run_len + 1 : 0;
        end
        prev_stall = host_stall;
        prev_ras   = mem_ras;
        prev_cas   = mem_cas;
    end

    // timed access, valid only with refresh off and queue empty
    task automatic acc(input logic we, input logic [2*HW-1:0] a, input logic d);
        @(negedge clk);
        host_valid = 1'b1; host_we = we; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_valid = 1'b0;
        @(negedge clk);
        chk(mem_ras && !mem_cas && mem_addr == a[HW-1:0], "R2 row phase", mem_addr, a[HW-1:0]);
        @(negedge clk);
        chk(mem_cas && !mem_ras && mem_addr == a[2*HW-1:HW] && mem_we == we,
            "R3 column phase", mem_addr, a[2*HW-1:HW]);
        if (we) chk(mem_wdata == d, "R3 write data", mem_wdata, d);
        @(negedge clk);
        chk(!mem_cas, "R5 cas one clock", mem_cas, 0);
        if (!we) chk(rd_valid && rd_data == d, "R4 read data", {rd_valid, rd_data}, {1'b1, d});
        else     chk(!rd_valid, "R4 no read valid on write", rd_valid, 0);
    endtask

    // untimed read: push and wait for data with a bound
    task automatic rd_wait(input logic [2*HW-1:0] a, input logic d);
        bit got = 0;
        @(negedge clk);
        host_valid = 1'b1; host_we = 1'b0; host_addr = a;
        @(negedge clk);
        host_valid = 1'b0;
        for (int k = 0; k < 200 && !got; k++) begin
            if (rd_valid) begin
                got = 1;
                chk(rd_data == d, "R4 read under refresh", rd_data, d);
            end else @(negedge clk);
        end
        chk(got, "R9 read served after burst", got, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!mem_ras && !mem_cas && !host_stall && !host_full && !rd_valid,
            "R1 reset state", {mem_ras, mem_cas, host_stall, host_full, rd_valid}, 0);
        rst_n = 1'b1;
        mon_en = 1;

        for (int a = 0; a < 256; a++) acc(1'b1, 8'(a), pat(8'(a)));
        for (int a = 0; a < 256; a++) acc(1'b0, 8'(a), pat(8'(a)));
        for (int a = 0; a < 256; a++) acc(1'b1, 8'(a), ~pat(8'(a)));
        for (int a = 0; a < 256; a++) acc(1'b0, 8'(a), ~pat(8'(a)));

        // idle refresh: fixed spacing
        exp_int = 100;
        spacing_mode = 1;
        @(negedge clk);
        rfsh_interval = 12'd100;
        while (rises < 4) @(negedge clk);
        spacing_mode = 0;

        // queue during a burst
        while (host_stall) @(negedge clk);
        while (!host_stall) @(negedge clk);
        hn = 0;
        begin
            logic [7:0] qa [4];
            bit got;
            int n;
            qa[0] = 8'h03; qa[1] = 8'h29; qa[2] = 8'h51; qa[3] = 8'hAE;
            for (int i = 0; i < 4; i++) begin
                chk(host_stall, "R9 stall while queuing", host_stall, 1);
                host_valid = 1'b1; host_we = 1'b0; host_addr = qa[i];
                @(negedge clk);
            end
            host_valid = 1'b0;
            chk(host_full, "R9 queue full", host_full, 1);
            n = 0;
            for (int k = 0; k < 300 && n < 4; k++) begin
                if (rd_valid) begin
                    chk(rd_data == ~pat(qa[n]), "R9 queued read data", rd_data, ~pat(qa[n]));
                    n++;
                end
                @(negedge clk);
            end
            got = (n == 4);
            chk(got, "R9 all queued reads served", n, 4);
            chk(hn >= 4, "R9 row phase count", hn, 4);
            for (int i = 0; i < 4; i++)
                chk(hist[i] == qa[i][HW-1:0], "R9 arrival order", hist[i], qa[i][HW-1:0]);
        end

        // host traffic interleaved with frequent refresh
        rfsh_interval = 12'd37;
        for (int a = 0; a < 256; a += 3) rd_wait(8'(a), ~pat(8'(a)));
        rfsh_interval = '0;
        while (host_stall) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(!host_stall && !mem_ras, "R6 interval 0 disables refresh", host_stall, 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    always @(negedge clk) begin
        if (cyc > 150000 && !done) begin
            done = 1;
            chk(1'b0, "watchdog", cyc, 150000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule